// File: doc/BRIEF.md
# I2C Register Target

This block is the target side of an I2C link in front of a file of eleven 8-bit registers. It samples SCL and SDA with the system clock, finds START, repeated START and STOP, and checks the 7-bit address in the control byte against a fixed prefix and three strap inputs. An internal register pointer is loaded from the byte that follows a write control byte. Later bytes in the same write go into the register file. A read control byte, usually sent after a repeated START, makes the block shift out the register at the pointer. Output goes through an open-drain enable, and every received byte is acknowledged.

A mode bit in the configuration register selects how the pointer moves. In the first setting it steps forward after each data byte and wraps from the last register to the first. In the second it stays on one register, so a master can poll that register repeatedly. A local host port reads and writes the same file, and it is the only path that can change the read-only capture register.

Top module: `i2c_reg_target`

## Requirements
- R1: A control byte is accepted only when its upper seven bits equal binary 0100 followed by `addr_sel[2:0]`; bit 0 is R/W (0 = write, 1 = read). An accepted control byte is ACKed. Any other control byte gets no ACK, and the block then neither drives SDA nor writes anything until the next START or STOP.
- R2: In a write, the first byte after the control byte loads the pointer from its low four bits. Each later byte is stored at the pointer once its eighth bit has been sampled. The block ACKs every byte of an accepted write.
- R3: `sda_oe` changes only while the synchronized SCL is low. ACK and read data bits are driven after an SCL falling edge.
- R4: After a control byte with R/W = 1, the block sends the register at the pointer MSB first. A master ACK starts the next byte. A master NACK releases SDA, and the block stays silent until START or STOP.
- R5: When bit 5 of register 0x05 is 0, the pointer advances by one after each written byte and after each read byte the master ACKs. From 0x0A, or from any higher value, it goes to 0x00.
- R6: When bit 5 of register 0x05 is 1, the pointer does not move. Repeated reads return the same register, and repeated writes overwrite the same register.
- R7: Register 0x08 cannot be written over I2C. A write to it is ACKed and leaves its contents unchanged.
- R8: A data byte that is cut off by a repeated START or a STOP before its eighth bit is not stored.
- R9: Synchronous active-high reset clears all registers (so bit 5 of register 0x05 is 0), releases SDA, and returns the block to idle.
- R10: `host_we` writes `host_wdata` to any register 0x00 to 0x0A at `host_waddr`. `host_rdata` shows the register at `host_raddr` one clock later, and addresses above 0x0A read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel | input | 3 | Low three bits of the target address |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 4 | Host write register index |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 4 | Host read register index |
| host_rdata | output | 8 | Registered host read data |

## Verification
Some properties are checked on every clock. The SDA enable may move only when SCL was low in the previous sample, and it must stay released in the idle and ignore states. Register writes may come only from a data byte that has just completed, and each such write must reach its register, except the capture register, which only the host port may change. Other behaviours need a whole transaction to show and are covered by the bench's scenarios: address matching, pointer advance and wrap, the fixed-pointer polling mode, the returned read values, and the discarding of a byte cut off by STOP or repeated START. Those scenarios are checked against a behavioural register model in the bench, and host reads are compared with that model on every clock between transactions.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  // Protocol phase of the target engine.
  typedef enum logic [2:0] {
    ST_IDLE,   // no transaction
    ST_CTRL,   // receiving the control byte
    ST_ADDR,   // receiving the register index byte
    ST_WDATA,  // receiving data bytes
    ST_RDATA,  // transmitting data bytes
    ST_WAIT    // ignoring the bus until START/STOP
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_val,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_d, sda_d;
  logic              scl_s, sda_s;

  // Bus idles high, so the pipes reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_hi    = scl_s;
  assign sda_val   = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges while SCL stays high are bus conditions.
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
  parameter int NREGS    = 11,
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter int RO_ADDR  = 8,
  parameter int CFG_ADDR = 5,
  parameter int SEQ_BIT  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_rdata,
  input  logic          host_we,
  input  logic [AW-1:0] host_waddr,
  input  logic [DW-1:0] host_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [DW-1:0] host_rdata,
  output logic          seq_fixed
);
  localparam logic [AW-1:0] LAST = AW'(NREGS - 1);

  logic [DW-1:0]    regs [NREGS];
  logic [NREGS-1:0] bus_hit, host_hit;

  // Per-register write decode; the capture register takes no bus writes.
  for (genvar g = 0; g < NREGS; g++) begin : g_dec
    if (g == RO_ADDR) begin : g_ro
      assign bus_hit[g] = 1'b0;
    end else begin : g_rw
      assign bus_hit[g] = bus_we && (bus_waddr == AW'(g));
    end
    assign host_hit[g] = host_we && (host_waddr == AW'(g));
  end

  // Small file kept in flops so that every entry has a reset value; the bus write wins a collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (bus_hit[i])       regs[i] <= bus_wdata;
        else if (host_hit[i]) regs[i] <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      host_rdata <= '0;
    end else begin
      bus_rdata  <= (bus_raddr  <= LAST) ? regs[bus_raddr]  : '0;
      host_rdata <= (host_raddr <= LAST) ? regs[host_raddr] : '0;
    end
  end

  assign seq_fixed = regs[CFG_ADDR][SEQ_BIT];

  // R7: the capture register changes only after a host write to it
  assert_ro_host_only_R7: assert property (@(posedge clk) disable iff (rst)
    (regs[RO_ADDR] != $past(regs[RO_ADDR])) |-> $past(host_we && (host_waddr == AW'(RO_ADDR))));

  // R2: a bus write to a writable register lands there on the next cycle
  assert_bus_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_waddr <= LAST) && (bus_waddr != AW'(RO_ADDR)))
      |=> (regs[$past(bus_waddr)] == $past(bus_wdata)));
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int          NREGS   = 11,
  parameter int          DW      = 8,
  parameter int          AW      = 4,
  parameter int          SELW    = 3,
  parameter logic [3:0]  CTRL_HI = 4'b0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_hi,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_val,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [SELW-1:0] addr_sel,
  input  logic            seq_fixed,
  input  logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   ptr,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            sda_oe
);
  localparam int              CW     = $clog2(DW + 3);
  localparam logic [CW-1:0]   C_LAST = CW'(DW - 1);
  localparam logic [CW-1:0]   C_FULL = CW'(DW);
  localparam logic [CW-1:0]   C_ACK  = CW'(DW + 1);
  localparam logic [CW-1:0]   C_NEXT = CW'(DW + 2);
  localparam logic [AW-1:0]   LAST   = AW'(NREGS - 1);

  tgt_state_t     st;
  logic [CW-1:0]  bcnt;
  logic [DW-2:0]  shreg;
  logic           rw;
  logic [DW-1:0]  byte_in;
  logic [AW-1:0]  ptr_nx;

  assign byte_in = {shreg, sda_val};
  assign ptr_nx  = seq_fixed ? ptr : ((ptr >= LAST) ? '0 : ptr + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_CTRL;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (scl_rise && bcnt < C_FULL) begin
              shreg <= byte_in[DW-2:0];
              bcnt  <= bcnt + 1'b1;
              if (bcnt == C_LAST) begin
                if (st == ST_CTRL) begin
                  if (byte_in[DW-1:1] == {CTRL_HI, addr_sel}) rw <= byte_in[0];
                  else                                         st <= ST_WAIT;
                end else if (st == ST_ADDR) begin
                  ptr <= byte_in[AW-1:0];
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= byte_in;
                  ptr     <= ptr_nx;
                end
              end
            end else if (scl_fall && bcnt == C_FULL) begin
              sda_oe <= 1'b1;          // acknowledge
              bcnt   <= C_ACK;
            end else if (scl_fall && bcnt == C_ACK) begin
              sda_oe <= 1'b0;
              bcnt   <= '0;
              if (st == ST_CTRL) begin
                if (rw) begin
                  st     <= ST_RDATA;
                  shreg  <= rd_data[DW-2:0];
                  sda_oe <= ~rd_data[DW-1];
                end else begin
                  st <= ST_ADDR;
                end
              end else if (st == ST_ADDR) begin
                st <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise && bcnt < C_FULL) begin
              bcnt <= bcnt + 1'b1;
            end else if (scl_rise && bcnt == C_ACK) begin
              if (!sda_val) begin
                ptr  <= ptr_nx;
                bcnt <= C_NEXT;
              end else begin
                st <= ST_WAIT;           // master NACK
              end
            end else if (scl_fall && bcnt != '0 && bcnt < C_FULL) begin
              shreg  <= {shreg[DW-3:0], 1'b0};
              sda_oe <= ~shreg[DW-2];
            end else if (scl_fall && bcnt == C_FULL) begin
              sda_oe <= 1'b0;            // let the master answer
              bcnt   <= C_ACK;
            end else if (scl_fall && bcnt == C_NEXT) begin
              shreg  <= rd_data[DW-2:0];
              sda_oe <= ~rd_data[DW-1];
              bcnt   <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: the SDA enable moves only after SCL was seen low
  assert_oe_on_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_hi));

  // R1, R4: SDA stays released while idle or ignoring the bus
  assert_quiet_ignore_R1: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) || (st == ST_WAIT)) |-> !sda_oe);

  // R2: register writes come only from a data byte completed on an SCL rise
  assert_write_from_data_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(st) == ST_WDATA) && $past(scl_rise));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         NREGS       = 11,
  parameter int         DW          = 8,
  parameter int         AW          = 4,
  parameter int         RO_ADDR     = 8,
  parameter int         CFG_ADDR    = 5,
  parameter int         SEQ_BIT     = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] CTRL_HI     = 4'b0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [2:0]    addr_sel,
  input  logic          host_we,
  input  logic [AW-1:0] host_waddr,
  input  logic [DW-1:0] host_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [DW-1:0] host_rdata
);
  localparam int SELW = 7 - $bits(CTRL_HI);

  logic          scl_hi, scl_rise, scl_fall, sda_val, start_det, stop_det;
  logic          seq_fixed, wr_en;
  logic [AW-1:0] ptr, wr_addr;
  logic [DW-1:0] wr_data, rd_data;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_hi(scl_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_val(sda_val), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm #(
    .NREGS(NREGS), .DW(DW), .AW(AW), .SELW(SELW), .CTRL_HI(CTRL_HI)
  ) u_fsm (
    .clk(clk), .rst(rst), .scl_hi(scl_hi), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_val(sda_val), .start_det(start_det),
    .stop_det(stop_det), .addr_sel(addr_sel[SELW-1:0]), .seq_fixed(seq_fixed),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  i2c_tgt_regfile #(
    .NREGS(NREGS), .DW(DW), .AW(AW), .RO_ADDR(RO_ADDR),
    .CFG_ADDR(CFG_ADDR), .SEQ_BIT(SEQ_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_we(wr_en), .bus_waddr(wr_addr),
    .bus_wdata(wr_data), .bus_raddr(ptr), .bus_rdata(rd_data),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata), .seq_fixed(seq_fixed)
  );
endmodule

// File: tb/i2c_reg_target_tb.sv
`timescale 1ns/1ps
module i2c_reg_target_tb;
  localparam int Q = 6;
  localparam logic [7:0] CW_OK = 8'h4A;  // 0100_101_0
  localparam logic [7:0] CR_OK = 8'h4B;  // 0100_101_1
  localparam logic [7:0] C_BAD = 8'h4E;  // address 0100_111

  logic       clk = 1'b0;
  logic       rst, scl_m, sda_m, host_we;
  logic [3:0] host_waddr, host_raddr;
  logic [7:0] host_wdata, host_rdata;
  logic       sda_oe;
  wire        sda_bus = sda_m & ~sda_oe;

  int         n_chk = 0, n_fail = 0;
  logic [7:0] model [11];
  int         mptr = 0;
  logic       cmp_on = 1'b0, cmp_prev = 1'b0, oe_prev = 1'b0;
  logic [3:0] raddr_seen = '0;

  always #2.5 clk = ~clk;

  i2c_reg_target u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .addr_sel(3'b101), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Host read address scans the file continuously.
  initial begin
    host_raddr = '0;
    forever begin
      @(posedge clk); #1;
      host_raddr = (host_raddr >= 4'd11) ? 4'd0 : host_raddr + 4'd1;
    end
  end

  // Per-clock comparison against the model, plus the SDA timing rule.
  always @(negedge clk) begin
    if (cmp_on && cmp_prev)
      chk("R10 host read vs model", host_rdata, (raddr_seen <= 4'd10) ? model[raddr_seen] : 8'h00);
    if (!rst && sda_oe !== oe_prev)
      chk("R3 sda_oe moved with SCL high", {7'b0, scl_m}, 8'h00);
    cmp_prev   = cmp_on;
    raddr_seen = host_raddr;
    oe_prev    = sda_oe;
  end

  task automatic m_start();
    sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q); sda_m = 1'b0; tk(Q); scl_m = 1'b0; tk(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tk(Q); scl_m = 1'b1; tk(Q); sda_m = 1'b1; tk(Q);
  endtask

  task automatic m_bit(input logic b);
    sda_m = b; tk(Q); scl_m = 1'b1; tk(2*Q); scl_m = 1'b0; tk(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q);
    ack = ~sda_bus;
    tk(Q); scl_m = 1'b0; tk(Q);
  endtask

  task automatic m_rbyte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q);
      d[i] = sda_bus;
      tk(Q); scl_m = 1'b0; tk(Q);
    end
    m_bit(~give_ack);
    sda_m = 1'b1;
  endtask

  function automatic int step(input int p);
    if (model[5][5]) return p;
    return (p >= 10) ? 0 : p + 1;
  endfunction

  task automatic wr_txn(input logic [7:0] a, input int n,
                        input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic       ack;
    logic [7:0] bt [3];
    int         nx;
    bt[0] = b0; bt[1] = b1; bt[2] = b2;
    cmp_on = 1'b0;
    m_start();
    m_wbyte(CW_OK, ack); chk("R1 matching write control ACK", {7'b0, ack}, 8'h01);
    m_wbyte(a, ack);     chk("R2 index byte ACK", {7'b0, ack}, 8'h01);
    mptr = int'(a[3:0]);
    for (int k = 0; k < n; k++) begin
      m_wbyte(bt[k], ack); chk("R2 data byte ACK", {7'b0, ack}, 8'h01);
      nx = step(mptr);                 // advance uses the mode before this byte
      if (mptr <= 10 && mptr != 8) model[mptr] = bt[k];   // R7 capture register
      mptr = nx;
    end
    m_stop(); tk(8);
    cmp_on = 1'b1;
  endtask

  task automatic rd_txn(input logic [7:0] a, input int n, input string tag);
    logic       ack;
    logic [7:0] d;
    cmp_on = 1'b0;
    m_start();
    m_wbyte(CW_OK, ack); chk("R1 control ACK", {7'b0, ack}, 8'h01);
    m_wbyte(a, ack);     chk("R2 index byte ACK", {7'b0, ack}, 8'h01);
    mptr = int'(a[3:0]);
    m_start();
    m_wbyte(CR_OK, ack); chk("R4 read control ACK", {7'b0, ack}, 8'h01);
    for (int k = 0; k < n; k++) begin
      m_rbyte(d, k < n - 1);
      chk(tag, d, (mptr <= 10) ? model[mptr] : 8'h00);
      if (k < n - 1) mptr = step(mptr);
    end
    chk("R4 SDA released after NACK", {7'b0, sda_oe}, 8'h00);
    m_stop(); tk(8);
    cmp_on = 1'b1;
  endtask

  initial begin
    logic ack;
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    host_we = 1'b0; host_waddr = '0; host_wdata = '0;
    for (int i = 0; i < 11; i++) model[i] = 8'h00;
    tk(6); rst = 1'b0; tk(2);

    // R9: reset state; contents scanned by the monitor
    chk("R9 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
    cmp_on = 1'b1; tk(40);

    // R2 / R5: sequential write then read-back
    wr_txn(8'h00, 3, 8'h11, 8'h22, 8'h33);
    rd_txn(8'h01, 2, "R4 read data sequential");

    // R1: wrong address, nothing acknowledged or stored
    cmp_on = 1'b0;
    m_start();
    m_wbyte(C_BAD, ack); chk("R1 mismatched control no ACK", {7'b0, ack}, 8'h00);
    m_wbyte(8'h00, ack); chk("R1 ignored byte no ACK", {7'b0, ack}, 8'h00);
    m_wbyte(8'h99, ack); chk("R1 ignored byte no ACK", {7'b0, ack}, 8'h00);
    m_stop(); tk(8); cmp_on = 1'b1;
    rd_txn(8'h00, 1, "R1 register untouched by ignored write");

    // R5: wrap from 0x0A to 0x00
    wr_txn(8'h09, 3, 8'hA1, 8'hA2, 8'hA3);
    rd_txn(8'h09, 3, "R5 read across wrap");

    // R10 host write to capture register, R7 bus write ignored there
    cmp_on = 1'b0;
    host_we = 1'b1; host_waddr = 4'd8; host_wdata = 8'h5A; tk(1);
    host_we = 1'b0; model[8] = 8'h5A; tk(3); cmp_on = 1'b1;
    wr_txn(8'h08, 2, 8'hFF, 8'hC3, 8'h00);
    rd_txn(8'h08, 2, "R7 capture register kept");

    // R8: byte cut by repeated START, then by STOP
    cmp_on = 1'b0;
    m_start();
    m_wbyte(CW_OK, ack); m_wbyte(8'h03, ack); m_wbyte(8'h44, ack);
    chk("R2 data byte ACK", {7'b0, ack}, 8'h01);
    model[3] = 8'h44;
    for (int i = 0; i < 4; i++) m_bit(1'b1);
    m_start(); m_stop(); tk(8);
    m_start();
    m_wbyte(CW_OK, ack); m_wbyte(8'h06, ack);
    for (int i = 0; i < 5; i++) m_bit(1'b1);
    m_stop(); tk(8); cmp_on = 1'b1;
    rd_txn(8'h03, 4, "R8 cut byte not stored");

    // R6: fixed pointer
    wr_txn(8'h05, 1, 8'h20, 8'h00, 8'h00);
    wr_txn(8'h02, 2, 8'h77, 8'h78, 8'h00);
    rd_txn(8'h02, 3, "R6 fixed pointer repeated read");
    rd_txn(8'h03, 1, "R6 neighbour untouched");
    tk(30);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule